// File: doc/BRIEF.md
# Dual-Core Idle and Wake Controller

This block governs the low-power idle state of two processor cores. A core asks to go idle by pulsing its wait strobe. On the next clock edge the controller takes away that core's clock enable and raises its halt acknowledge, which tells the rest of the system that the core is waiting for an interrupt. The halt acknowledge levels are also driven out as a status word that software can read.

An idle core is released when an interrupt aimed at it qualifies. Whether it qualifies depends on both cores. A core counts as stopped when it is idle or when software holds it disabled (in reset). If every other core is stopped, only a non-maskable interrupt can wake the idle core. Otherwise, either a non-maskable or an external interrupt wakes it. On wake, the clock enable returns, the halt acknowledge drops, and the core receives a one-cycle wake pulse so that it can go and service the interrupt.

All pins are plain control and status levels. No data moves through the block, so it has no valid/ready handshake. The core count is a parameter whose default is two.

Top module: `core_idle_ctrl`

## Requirements
- R1: After reset, every core is running: clk_en is all ones, halt_ack is all zeros and wake_pulse is all zeros.
- R2: If an enabled, running core has wait_req high in a cycle with no qualifying interrupt, then after that clock edge its halt_ack is 1 and its clk_en is 0. Both stay that way while the core is idle.
- R3: Bit i of status_halt always equals halt_ack bit i.
- R4: If an idle, enabled core sees its nmi high, then after that edge its halt_ack is 0, its clk_en is 1 and its wake_pulse is 1.
- R5: If an idle, enabled core sees its ext_irq high while at least one other core is neither idle nor disabled, it wakes as in R4.
- R6: If an idle core sees no nmi while every other core is idle or disabled, it stays idle and gives no wake pulse, even when its ext_irq is high.
- R7: While core_dis bit i is high, core i is forced out of idle after the next edge. It gives no wake pulse, and it ignores its wait_req, ext_irq and nmi.
- R8: If an enabled, running core has wait_req and a qualifying interrupt in the same cycle, it stays running and gives no wake pulse.
- R9: wake_pulse bit i is high for exactly one cycle, and only in the cycle right after core i leaves idle through an interrupt.
- R10: Interrupts sent to a running core do not change its state and do not produce a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req | input | NUM_CORES | Per-core wait strobe that requests idle |
| core_dis | input | NUM_CORES | Per-core software disable (hold in reset) |
| ext_irq | input | NUM_CORES | Per-core external interrupt request |
| nmi | input | NUM_CORES | Per-core non-maskable interrupt |
| clk_en | output | NUM_CORES | Per-core clock enable; low while the core is idle |
| halt_ack | output | NUM_CORES | Per-core halt acknowledge; high while the core is idle |
| wake_pulse | output | NUM_CORES | One-cycle pulse on leaving idle |
| status_halt | output | NUM_CORES | Software-readable copy of the halt acknowledges |

## Verification
On every cycle the assertions check idle entry, wake by non-maskable interrupt, wake by external interrupt when another core is running, and blocking of external wakes when all other cores are stopped. They also check that a disabled core is forced out of idle, that a wait strobe loses to a simultaneous interrupt, and that each wake pulse follows a real exit from idle. Other behaviours can only be shown by the bench's scenarios. These are the reset state, the status word tracking the halt bits, and the sequences that cross the two cores: one core is disabled or woken while the other is idle, and then a wake is released again.

// File: rtl/core_idle_pkg.sv
package core_idle_pkg;
  typedef enum logic {
    CORE_RUN  = 1'b0,
    CORE_IDLE = 1'b1
  } core_mode_e;
endpackage

// File: rtl/stop_vote.sv
// For each core, reports whether every other core is stopped (idle or disabled).
module stop_vote #(
  parameter int NUM_CORES = 2
) (
  input  logic [NUM_CORES-1:0] idle,
  input  logic [NUM_CORES-1:0] dis,
  output logic [NUM_CORES-1:0] others_stopped
);
  logic [NUM_CORES-1:0] stopped;
  assign stopped = idle | dis;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_vote
    always_comb begin
      others_stopped[i] = 1'b1;
      for (int j = 0; j < NUM_CORES; j++) begin
        if (j != i) others_stopped[i] = others_stopped[i] & stopped[j];
      end
    end
  end
endmodule

// File: rtl/wake_qual.sv
// Decides which interrupt may release each core.
module wake_qual #(
  parameter int NUM_CORES = 2
) (
  input  logic [NUM_CORES-1:0] nmi,
  input  logic [NUM_CORES-1:0] ext_irq,
  input  logic [NUM_CORES-1:0] others_stopped,
  output logic [NUM_CORES-1:0] wake_ok
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_qual
    assign wake_ok[i] = nmi[i] | (ext_irq[i] & ~others_stopped[i]);
  end
endmodule

// File: rtl/core_idle_fsm.sv
// State of one core: running or idle, with a registered wake pulse.
module core_idle_fsm
  import core_idle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic dis,
  input  logic wake_ok,
  output logic idle,
  output logic wake_pulse
);
  core_mode_e mode_q, mode_d;
  logic       pulse_d;

  always_comb begin
    mode_d  = mode_q;
    pulse_d = 1'b0;
    if (dis) begin
      mode_d = CORE_RUN;
    end else begin
      case (mode_q)
        CORE_RUN:  if (wait_req && !wake_ok) mode_d = CORE_IDLE;
        CORE_IDLE: if (wake_ok) begin
          mode_d  = CORE_RUN;
          pulse_d = 1'b1;
        end
        default:   mode_d = CORE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= CORE_RUN;
      wake_pulse <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      wake_pulse <= pulse_d;
    end
  end

  assign idle = (mode_q == CORE_IDLE);
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl #(
  parameter int NUM_CORES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] wait_req,
  input  logic [NUM_CORES-1:0] core_dis,
  input  logic [NUM_CORES-1:0] ext_irq,
  input  logic [NUM_CORES-1:0] nmi,
  output logic [NUM_CORES-1:0] clk_en,
  output logic [NUM_CORES-1:0] halt_ack,
  output logic [NUM_CORES-1:0] wake_pulse,
  output logic [NUM_CORES-1:0] status_halt
);
  logic [NUM_CORES-1:0] idle_vec;
  logic [NUM_CORES-1:0] others_stopped;
  logic [NUM_CORES-1:0] wake_ok;

  stop_vote #(.NUM_CORES(NUM_CORES)) u_vote (
    .idle           (idle_vec),
    .dis            (core_dis),
    .others_stopped (others_stopped)
  );

  wake_qual #(.NUM_CORES(NUM_CORES)) u_qual (
    .nmi            (nmi),
    .ext_irq        (ext_irq),
    .others_stopped (others_stopped),
    .wake_ok        (wake_ok)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    core_idle_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wait_req   (wait_req[i]),
      .dis        (core_dis[i]),
      .wake_ok    (wake_ok[i]),
      .idle       (idle_vec[i]),
      .wake_pulse (wake_pulse[i])
    );
  end

  assign halt_ack    = idle_vec;
  assign clk_en      = ~idle_vec;
  assign status_halt = idle_vec;
endmodule

// File: rtl/core_idle_chk.sv
module core_idle_chk #(
  parameter int NUM_CORES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] wait_req,
  input logic [NUM_CORES-1:0] core_dis,
  input logic [NUM_CORES-1:0] ext_irq,
  input logic [NUM_CORES-1:0] nmi,
  input logic [NUM_CORES-1:0] clk_en,
  input logic [NUM_CORES-1:0] halt_ack,
  input logic [NUM_CORES-1:0] wake_pulse
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    logic others;
    always_comb begin
      others = 1'b1;
      for (int j = 0; j < NUM_CORES; j++) begin
        if (j != i) others = others & (halt_ack[j] | core_dis[j]);
      end
    end

    assert_enter_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_ack[i] && !core_dis[i] && wait_req[i] && !nmi[i] && !(ext_irq[i] && !others))
      |=> (halt_ack[i] && !clk_en[i]));

    assert_nmi_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_ack[i] && !core_dis[i] && nmi[i])
      |=> (!halt_ack[i] && clk_en[i] && wake_pulse[i]));

    assert_ext_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_ack[i] && !core_dis[i] && ext_irq[i] && !others)
      |=> (!halt_ack[i] && wake_pulse[i]));

    assert_ext_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_ack[i] && !core_dis[i] && !nmi[i] && others)
      |=> (halt_ack[i] && !wake_pulse[i]));

    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      core_dis[i] |=> (!halt_ack[i] && !wake_pulse[i]));

    assert_tie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_ack[i] && !core_dis[i] && wait_req[i] && nmi[i])
      |=> (!halt_ack[i] && !wake_pulse[i]));

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse[i] |-> (!halt_ack[i] && clk_en[i] && $past(halt_ack[i])));
  end
endmodule

bind core_idle_ctrl core_idle_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/test_core_idle_ctrl.sv
module test_core_idle_ctrl;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] wait_req, core_dis, ext_irq, nmi;
  logic [NC-1:0] clk_en, halt_ack, wake_pulse, status_halt;

  core_idle_ctrl #(.NUM_CORES(NC)) i_core_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .core_dis(core_dis),
    .ext_irq(ext_irq), .nmi(nmi), .clk_en(clk_en), .halt_ack(halt_ack),
    .wake_pulse(wake_pulse), .status_halt(status_halt)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [NC-1:0] m_idle, m_wake;
  string m_tag [NC];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NC; i++) begin
      chk(halt_ack[i] == m_idle[i], m_tag[i], 32'(halt_ack[i]), 32'(m_idle[i]));
      chk(clk_en[i] == !m_idle[i], m_tag[i], 32'(clk_en[i]), 32'(!m_idle[i]));
      chk(wake_pulse[i] == m_wake[i], m_tag[i], 32'(wake_pulse[i]), 32'(m_wake[i]));
      chk(status_halt[i] == halt_ack[i], "R3", 32'(status_halt[i]), 32'(halt_ack[i]));
    end
  endtask

  // Reference model: next state from the requirements.
  task automatic model_step();
    logic [NC-1:0] n_idle, n_wake;
    for (int i = 0; i < NC; i++) begin
      bit others = 1'b1;
      bit q;
      for (int j = 0; j < NC; j++) if (j != i) others = others & (m_idle[j] | core_dis[j]);
      q = nmi[i] | (ext_irq[i] & !others);
      n_wake[i] = 1'b0;
      n_idle[i] = m_idle[i];
      if (core_dis[i]) begin
        n_idle[i] = 1'b0; m_tag[i] = "R7";
      end else if (m_idle[i]) begin
        if (q) begin
          n_idle[i] = 1'b0; n_wake[i] = 1'b1;
          m_tag[i] = nmi[i] ? "R4" : "R5";
        end else m_tag[i] = "R6";
      end else if (wait_req[i]) begin
        n_idle[i] = !q; m_tag[i] = q ? "R8" : "R2";
      end else m_tag[i] = "R10";
    end
    m_idle = n_idle;
    m_wake = n_wake;
  endtask

  task automatic cyc(input logic [NC-1:0] w, input logic [NC-1:0] d,
                     input logic [NC-1:0] e, input logic [NC-1:0] n);
    wait_req = w; core_dis = d; ext_irq = e; nmi = n;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    wait_req = '0; core_dis = '0; ext_irq = '0; nmi = '0;
    m_idle = '0; m_wake = '0;
    for (int i = 0; i < NC; i++) m_tag[i] = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();
    chk(clk_en == 2'b11, "R1", 32'(clk_en), 32'h3);

    cyc(2'b11, 2'b00, 2'b00, 2'b00);
    chk(halt_ack == 2'b11 && clk_en == 2'b00, "R2", 32'(halt_ack), 32'h3);
    cyc(2'b00, 2'b00, 2'b01, 2'b00);
    chk(halt_ack == 2'b11 && wake_pulse == 2'b00, "R6", 32'(halt_ack), 32'h3);
    cyc(2'b00, 2'b00, 2'b00, 2'b10);
    chk(halt_ack == 2'b01 && wake_pulse == 2'b10, "R4", 32'(wake_pulse), 32'h2);
    cyc(2'b00, 2'b00, 2'b00, 2'b00);
    chk(wake_pulse == 2'b00, "R9", 32'(wake_pulse), 32'h0);
    cyc(2'b00, 2'b00, 2'b01, 2'b00);
    chk(halt_ack == 2'b00 && wake_pulse == 2'b01, "R5", 32'(wake_pulse), 32'h1);
    cyc(2'b00, 2'b10, 2'b00, 2'b00);
    cyc(2'b01, 2'b10, 2'b00, 2'b00);
    chk(halt_ack == 2'b01, "R2", 32'(halt_ack), 32'h1);
    cyc(2'b00, 2'b10, 2'b01, 2'b00);
    chk(halt_ack == 2'b01 && wake_pulse == 2'b00, "R6", 32'(halt_ack), 32'h1);
    cyc(2'b10, 2'b10, 2'b10, 2'b10);
    chk(halt_ack[1] == 1'b0 && wake_pulse[1] == 1'b0, "R7", 32'(halt_ack), 32'h1);
    cyc(2'b00, 2'b00, 2'b00, 2'b01);
    chk(halt_ack == 2'b00 && wake_pulse == 2'b01, "R4", 32'(wake_pulse), 32'h1);
    cyc(2'b01, 2'b00, 2'b00, 2'b01);
    chk(halt_ack == 2'b00 && wake_pulse == 2'b00, "R8", 32'(halt_ack), 32'h0);
    cyc(2'b01, 2'b00, 2'b01, 2'b00);
    chk(halt_ack == 2'b00 && wake_pulse == 2'b00, "R8", 32'(halt_ack), 32'h0);
    cyc(2'b00, 2'b00, 2'b11, 2'b11);
    chk(halt_ack == 2'b00 && wake_pulse == 2'b00, "R10", 32'(wake_pulse), 32'h0);
    cyc(2'b01, 2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b01, 2'b00, 2'b00);
    chk(halt_ack == 2'b00 && wake_pulse == 2'b00, "R7", 32'(halt_ack), 32'h0);

    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [NC-1:0] w, d, e, n;
      for (int i = 0; i < NC; i++) begin
        w[i] = ($urandom % 3) == 0;
        d[i] = ($urandom % 8) == 0;
        e[i] = ($urandom % 4) == 0;
        n[i] = ($urandom % 10) == 0;
      end
      cyc(w, d, e, n);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule